// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit gathers event flags for a serial bus controller and turns them into one level interrupt and two DMA request lines. The transfer logic raises events through a one-cycle set vector. Software reaches four registers over a simple strobed register bus: a status register, an interrupt-enable register, a buffer-configuration register and a vector register. Reading the vector register returns the lowest-numbered event that is both pending and enabled, and clears that one event.

Status bits are cleared by writing ones, except for the two data-ready flags, bit 3 (receive ready) and bit 4 (transmit ready). Those two are cleared only by the transfer logic, through a separate hardware clear vector. Setting a DMA enable in the buffer register turns off the matching ready interrupt enable, so a ready flag is served by DMA or by interrupt but never by both. Writing ones to bits 14 and 6 of the buffer register does not store them. Instead each gives a one-cycle flush command, for the receive queue and the transmit queue.

The register bus samples `reg_wr` or `reg_rd` on a rising clock edge. Register select values are 0 for status, 1 for enable, 2 for vector and 3 for buffer configuration. Read data is registered and is valid in the cycle after the read strobe. Registers, the interrupt line, the DMA request lines and the flush outputs all update on the same edge.

Top module: `irq_vec_unit`

## Requirements
- R1: `irq_o` is 1 exactly when (status AND enable) is non-zero, and it updates on the same edge as the registers.
- R2: `drq_rx_o` equals status bit 3 while buffer bit 15 is 1, and is 0 otherwise. `drq_tx_o` equals status bit 4 while buffer bit 7 is 1, and is 0otherwise.
- R3: A read of select 2 returns the 1-based index of the lowest set bit of (status AND enable), or 0 if there is none. It clears only that status bit.
- R4: A write to select 0 clears the status bits written as 1 that lie within 0x63E7. Every other bit, including bits 3, 4 and 12, is left unchanged.
- R5: A write to select 1 stores only the bits within 0x63FF.
- R6: A buffer write with bit 15 set clears enable bit 3. A buffer write with bit 7 set clears enable bit 4.
- R7: A buffer write stores only the bits within 0xBFBF. Bit 14 gives a one-cycle `rx_flush_o` pulse and bit 6 gives a one-cycle `tx_flush_o` pulse.
- R8: A status read returns the stored status ORed with `bus_busy` in bit 12.
- R9: An `ev_set` bit sets its status bit even when a software clear, a vector clear or a hardware clear hits that bit in the same cycle.
- R10: After reset, all registers, read data and outputs are zero.
- R11: `hw_clr` bits clear the matching status bits, including bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select (0 status, 1 enable, 2 vector, 3 buffer) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data, valid the cycle after `reg_rd` |
| ev_set | input | 16 | One-cycle event set pulses from the transfer logic |
| hw_clr | input | 16 | Hardware status clear pulses |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 |
| irq_o | output | 1 | Level interrupt |
| drq_rx_o | output | 1 | Receive DMA request |
| drq_tx_o | output | 1 | Transmit DMA request |
| rx_flush_o | output | 1 | One-cycle receive queue flush command |
| tx_flush_o | output | 1 | One-cycle transmit queue flush command |

## Verification
A status bit that is wrongly kept or wrongly dropped shows up on the very next edge, as an interrupt or DMA level that disagrees with the visible registers. It also shows up on the next status or vector read. A fault in the lowest-bit picker gives either a wrong index or a sequence of vector reads that does not drain the pending set in ascending order. Draining several set patterns completely shows both kinds of fault within a few reads. A wrong clear mask or a wrong enable mask appears as a wrong value on the first readback after a write of all ones.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_BUFCFG = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ivu_status_reg.sv
module ivu_status_reg #(
    parameter int          W        = 16,
    parameter logic [15:0] CLR_MASK = 16'h63E7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] hw_clr_i,
    input  logic [W-1:0] sw_clr_i,
    input  logic [W-1:0] vec_clr_i,
    output logic [W-1:0] status_q,
    output logic [W-1:0] status_n
);
    localparam logic [W-1:0] SW_MASK = W'(CLR_MASK);

    logic [W-1:0] clr_all;

    always_comb begin
        clr_all  = (sw_clr_i & SW_MASK) | hw_clr_i | vec_clr_i;
        // A set pulse wins over every clear source in the same cycle.
        status_n = (status_q & ~clr_all) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_n;
    end
endmodule

// File: rtl/ivu_lowest_pick.sv
module ivu_lowest_pick #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     pend_i,
    output logic [W-1:0]     onehot_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign onehot_o[g] = pend_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | pend_i[g];
    end

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < W; k++) begin
            if (onehot_o[k]) idx_o = idx_o | IDX_W'(k + 1);
        end
    end
endmodule

// File: rtl/ivu_out_stage.sv
module ivu_out_stage #(
    parameter int W          = 16,
    parameter int RX_RDY_BIT = 3,
    parameter int TX_RDY_BIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_n,
    input  logic [W-1:0] enable_n,
    input  logic         rx_dma_en_n,
    input  logic         tx_dma_en_n,
    output logic         irq_o,
    output logic         drq_rx_o,
    output logic         drq_tx_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            drq_rx_o <= 1'b0;
            drq_tx_o <= 1'b0;
        end else begin
            irq_o    <= |(status_n & enable_n);
            drq_rx_o <= rx_dma_en_n & status_n[RX_RDY_BIT];
            drq_tx_o <= tx_dma_en_n & status_n[TX_RDY_BIT];
        end
    end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
    parameter int          W             = 16,
    parameter logic [15:0] CLR_MASK      = 16'h63E7,
    parameter logic [15:0] EN_MASK       = 16'h63FF,
    parameter logic [15:0] BUF_MASK      = 16'hBFBF,
    parameter int          RX_RDY_BIT    = 3,
    parameter int          TX_RDY_BIT    = 4,
    parameter int          BUSY_BIT      = 12,
    parameter int          RX_DMA_EN_BIT = 15,
    parameter int          TX_DMA_EN_BIT = 7,
    parameter int          RX_FLUSH_BIT  = 14,
    parameter int          TX_FLUSH_BIT  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] ev_set,
    input  logic [W-1:0] hw_clr,
    input  logic         bus_busy,
    output logic         irq_o,
    output logic         drq_rx_o,
    output logic         drq_tx_o,
    output logic         rx_flush_o,
    output logic         tx_flush_o
);
    import ivu_pkg::*;

    localparam int           IDX_W  = $clog2(W + 1);
    localparam logic [W-1:0] EN_M   = W'(EN_MASK);
    localparam logic [W-1:0] BUF_M  = W'(BUF_MASK);

    reg_sel_e     sel;
    logic         wr_status, wr_enable, wr_bufcfg, rd_vector;
    logic [W-1:0] status_q, status_n;
    logic [W-1:0] enable_q, enable_n;
    logic [W-1:0] bufcfg_q, bufcfg_n;
    logic [W-1:0] pend, pick_onehot, vec_clr, sw_clr, dma_kill;
    logic [IDX_W-1:0] pick_idx;

    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        wr_status = reg_wr && (sel == SEL_STATUS);
        wr_enable = reg_wr && (sel == SEL_ENABLE);
        wr_bufcfg = reg_wr && (sel == SEL_BUFCFG);
        rd_vector = reg_rd && (sel == SEL_VECTOR);
    end

    assign pend    = status_q & enable_q;
    assign vec_clr = rd_vector ? pick_onehot : '0;
    assign sw_clr  = wr_status ? reg_wdata : '0;

    ivu_lowest_pick #(.W(W), .IDX_W(IDX_W)) u_pick (
        .pend_i   (pend),
        .onehot_o (pick_onehot),
        .idx_o    (pick_idx)
    );

    ivu_status_reg #(.W(W), .CLR_MASK(CLR_MASK)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ev_set),
        .hw_clr_i  (hw_clr),
        .sw_clr_i  (sw_clr),
        .vec_clr_i (vec_clr),
        .status_q  (status_q),
        .status_n  (status_n)
    );

    // A DMA enable in a buffer write drops the matching ready interrupt enable.
    always_comb begin
        dma_kill = '0;
        dma_kill[RX_RDY_BIT] = reg_wdata[RX_DMA_EN_BIT];
        dma_kill[TX_RDY_BIT] = reg_wdata[TX_DMA_EN_BIT];
        if (wr_enable)      enable_n = reg_wdata & EN_M;
        else if (wr_bufcfg) enable_n = enable_q & ~dma_kill;
        else                enable_n = enable_q;
        bufcfg_n = wr_bufcfg ? (reg_wdata & BUF_M) : bufcfg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q   <= '0;
            bufcfg_q   <= '0;
            rx_flush_o <= 1'b0;
            tx_flush_o <= 1'b0;
        end else begin
            enable_q   <= enable_n;
            bufcfg_q   <= bufcfg_n;
            rx_flush_o <= wr_bufcfg && reg_wdata[RX_FLUSH_BIT];
            tx_flush_o <= wr_bufcfg && reg_wdata[TX_FLUSH_BIT];
        end
    end

    ivu_out_stage #(.W(W), .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_n    (status_n),
        .enable_n    (enable_n),
        .rx_dma_en_n (bufcfg_n[RX_DMA_EN_BIT]),
        .tx_dma_en_n (bufcfg_n[TX_DMA_EN_BIT]),
        .irq_o       (irq_o),
        .drq_rx_o    (drq_rx_o),
        .drq_tx_o    (drq_tx_o)
    );

    logic [W-1:0] busy_vec;
    always_comb begin
        busy_vec = '0;
        busy_vec[BUSY_BIT] = bus_busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (sel)
                SEL_STATUS: reg_rdata <= status_q | busy_vec;
                SEL_ENABLE: reg_rdata <= enable_q;
                SEL_VECTOR: reg_rdata <= W'(pick_idx);
                SEL_BUFCFG: reg_rdata <= bufcfg_q;
                default:    reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] ev_set,
    input logic [15:0] hw_clr,
    input logic        irq_o,
    input logic        drq_rx_o,
    input logic        drq_tx_o,
    input logic        rx_flush_o,
    input logic        tx_flush_o,
    input logic [15:0] status_q,
    input logic [15:0] enable_q,
    input logic [15:0] bufcfg_q
);
    logic [15:0] pend_c, low_c;
    logic        vrd, wst, wbuf;
    assign pend_c = status_q & enable_q;
    assign low_c  = pend_c & (~pend_c + 16'd1);
    assign vrd    = reg_rd && reg_addr == 2'd2;
    assign wst    = reg_wr && reg_addr == 2'd0;
    assign wbuf   = reg_wr && reg_addr == 2'd3;

    p_irq_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_c != 16'd0));
    p_drq_rx_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bufcfg_q[15] |-> !drq_rx_o);
    p_drq_tx_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bufcfg_q[7] |-> !drq_tx_o);
    p_vec_clears_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd && pend_c != 16'd0 && (ev_set & low_c) == 16'd0)
        |=> (status_q & $past(low_c)) == 16'd0);
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wst |=> (status_q & $past(reg_wdata & 16'h63E7 & ~ev_set)) == 16'd0);
    p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wst && status_q[3] && !hw_clr[3] && !vrd) |=> status_q[3]);
    p_dma_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wbuf && reg_wdata[15]) |=> !enable_q[3]);
    p_rx_flush_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush_o |-> $past(wbuf && reg_wdata[14]));
    p_tx_flush_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush_o |-> $past(wbuf && reg_wdata[6]));
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q & $past(ev_set)) == $past(ev_set));
endmodule

bind irq_vec_unit ivu_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ev_set     (ev_set),
    .hw_clr     (hw_clr),
    .irq_o      (irq_o),
    .drq_rx_o   (drq_rx_o),
    .drq_tx_o   (drq_tx_o),
    .rx_flush_o (rx_flush_o),
    .tx_flush_o (tx_flush_o),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .bufcfg_q   (bufcfg_q)
);

// File: tb/irq_vec_unit_tb_top.sv
`timescale 1ns/100ps
module irq_vec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0, ev_set = 16'd0, hw_clr = 16'd0;
    logic        bus_busy = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_o, drq_rx_o, drq_tx_o, rx_flush_o, tx_flush_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_vec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_set(ev_set), .hw_clr(hw_clr), .bus_busy(bus_busy),
        .irq_o(irq_o), .drq_rx_o(drq_rx_o), .drq_tx_o(drq_tx_o),
        .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] s, input logic [15:0] c);
        @(negedge clk);
        ev_set = s; hw_clr = c;
        @(negedge clk);
        ev_set = 16'd0; hw_clr = 16'd0;
    endtask

    function automatic logic [15:0] low_idx(input logic [15:0] v);
        for (int b = 0; b < 16; b++) if (v[b]) return 16'(b + 1);
        return 16'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, p, e, em, pend, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 irq", {15'd0, irq_o}, 16'd0);
        check("R10 drq", {14'd0, drq_rx_o, drq_tx_o}, 16'd0);
        check("R10 flush", {14'd0, rx_flush_o, tx_flush_o}, 16'd0);
        check("R10 rdata", reg_rdata, 16'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R10 reg", d, 16'd0);
        end

        // R5: enable mask
        wr(2'd1, 16'hFFFF); rd(2'd1, d);
        check("R5 enable mask", d, 16'h63FF);

        // R4/R11: W1C sweep per bit
        for (int b = 0; b < 16; b++) begin
            pulse(16'hFFFF, 16'd0);
            wr(2'd0, 16'(1 << b));
            rd(2'd0, d);
            exp = 16'h63E7 >> b;
            check("R4 w1c bit", d, exp[0] ? ~16'(1 << b) : 16'hFFFF);
            pulse(16'd0, 16'hFFFF);
        end
        pulse(16'hFFFF, 16'd0);
        wr(2'd0, 16'hFFFF); rd(2'd0, d);
        check("R4 w1c all", d, 16'h9C18);
        pulse(16'd0, 16'h0018); rd(2'd0, d);
        check("R11 hw clear ready", d, 16'h9C00);
        pulse(16'd0, 16'hFFFF);

        // R8: busy bit on status read
        bus_busy = 1'b1; rd(2'd0, d);
        check("R8 busy", d, 16'h1000);
        bus_busy = 1'b0; rd(2'd0, d);
        check("R8 idle", d, 16'h0000);

        // R1: interrupt level
        wr(2'd1, 16'h0001);
        pulse(16'h0002, 16'd0);
        check("R1 masked", {15'd0, irq_o}, 16'd0);
        pulse(16'h0001, 16'd0);
        check("R1 enabled", {15'd0, irq_o}, 16'd1);
        wr(2'd0, 16'h0001);
        check("R1 cleared", {15'd0, irq_o}, 16'd0);
        pulse(16'd0, 16'hFFFF);

        // R3: vector drain sweep
        for (int k = 0; k < 8; k++) begin
            p  = 16'hA5C3 ^ 16'(k * 16'h1357);
            e  = 16'hFFFF ^ 16'(k * 16'h0F11);
            em = e & 16'h63FF;
            wr(2'd1, e);
            pulse(p, 16'd0);
            pend = p & em;
            for (int r = 0; r < 17; r++) begin
                rd(2'd2, d);
                check("R3 vector", d, low_idx(pend));
                if (pend != 0) pend = pend & ~16'(1 << (low_idx(pend) - 1));
                if (d == 16'd0) break;
            end
            rd(2'd0, d);
            check("R3 drained status", d, p & ~em);
            check("R1 after drain", {15'd0, irq_o}, 16'd0);
            pulse(16'd0, 16'hFFFF);
        end

        // R6/R7: buffer write
        wr(2'd1, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        check("R7 rx flush pulse", {15'd0, rx_flush_o}, 16'd1);
        check("R7 tx flush pulse", {15'd0, tx_flush_o}, 16'd1);
        @(negedge clk);
        check("R7 flush self clear", {14'd0, rx_flush_o, tx_flush_o}, 16'd0);
        rd(2'd3, d);
        check("R7 buffer mask", d, 16'hBFBF);
        rd(2'd1, d);
        check("R6 enable kill", d, 16'h63E7);
        wr(2'd1, 16'h0018);
        wr(2'd3, 16'h0080); rd(2'd1, d);
        check("R6 tx only kill", d, 16'h0008);

        // R2: DMA gating
        wr(2'd3, 16'h0000);
        pulse(16'h0018, 16'd0);
        check("R2 rx gated off", {15'd0, drq_rx_o}, 16'd0);
        check("R2 tx gated off", {15'd0, drq_tx_o}, 16'd0);
        wr(2'd3, 16'h8000);
        check("R2 rx on", {15'd0, drq_rx_o}, 16'd1);
        check("R2 tx still off", {15'd0, drq_tx_o}, 16'd0);
        wr(2'd3, 16'h0080);
        check("R2 tx on", {15'd0, drq_tx_o}, 16'd1);
        pulse(16'd0, 16'h0010);
        check("R2 tx follows clear", {15'd0, drq_tx_o}, 16'd0);
        pulse(16'd0, 16'hFFFF);

        // R9: set wins over same-cycle W1C
        @(negedge clk);
        ev_set = 16'h0001; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
        @(negedge clk);
        ev_set = 16'd0; reg_wr = 1'b0; reg_wdata = 16'd0;
        rd(2'd0, d);
        check("R9 set priority", d, 16'h0001);
        @(negedge clk);
        ev_set = 16'h0008; hw_clr = 16'h0008;
        @(negedge clk);
        ev_set = 16'd0; hw_clr = 16'd0;
        rd(2'd0, d);
        check("R9 set over hw clear", d, 16'h0009);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule